// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This unit gives software a way to measure the traffic a DRAM controller handles. Eight 32-bit counters are wired one-to-one to eight event strobes from the controller: write data beats, read data beats, write commands, read commands, precharges, activates, rank switches and read/write turnarounds. There is no event selection. The hardware wiring decides which counter sees which event.

Software reaches the unit over a simple register bus. One register holds a global run bit and another holds a per-counter enable mask. Each counter can be read, and it can be written to preload a starting value, which sets its overflow period. A counter that wraps past its maximum latches an overflow flag. Each flag can be masked. A single level interrupt is raised while any unmasked flag is set, and software removes a flag by writing a one to its bit in a clear register.

Reads return data in the same cycle as the address. Writes take effect at the next rising clock edge.

Top module: `mc_perf_unit`

## Requirements
- R1: After reset all counters read 0, the control register reads 0, the per-counter enable register reads 0, the interrupt mask register reads 0x000000FF (all counters masked), the overflow status register reads 0, and `irq` is low.
- R2: Counter n increases by exactly one on each rising edge at which all three of these hold: `evt[n]` is high, bit 1 of the control register (offset 0x010) is set, and bit n of the enable register (offset 0x6C0) is set.
- R3: While control bit 1 is clear, no counter changes except through a software write. Only bit 1 of the control register is stored. All of its other bits read 0.
- R4: A counter whose enable bit is clear holds its value even while its event strobe is high and the global run bit is set.
- R5: Counters 0 to 7 are read and written at offsets 0x380, 0x384, 0x388, 0x38C, 0x3C0, 0x3C4, 0x3CC and 0x3D0 in that order. A write loads the written value.
- R6: When a software write to a counter lands on the same edge as an increment of that counter, the written value is stored and the increment is dropped.
- R7: An increment of a counter that holds 0xFFFFFFFF wraps it to 0 and sets bit n of the status register (offset 0x6CC) on the same edge.
- R8: Writing to the clear register (offset 0x6D0) clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. An overflow on the same edge as a clear of the same bit leaves that bit set.
- R9: `irq` is high exactly when some status bit n is set while bit n of the mask register (offset 0x6C8) is 0.
- R10: Offset 0x710 reads the `VERSION` parameter (default 0x00010A00), and writes to that offset have no effect.
- R11: Writes to the status register are ignored, and reads from addresses that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt | input | 8 | Event strobes, bit n feeds counter n |
| irq | output | 1 | Level interrupt for unmasked overflows |

## Verification
The hardest situations to reach from the ports are the two same-edge collisions. In one, a software write lands on a counter's increment. In the other, a clear write lands on a fresh overflow of the same bit. To reach them, the bench preloads a counter to within one count of wrapping. It then drives the event strobe and the conflicting bus write in the same cycle, so that both meet at one edge. After that it reads back the counter, the status register and `irq`. A plain preload just below the maximum, followed by two event cycles, exercises the ordinary wrap.

// File: rtl/mc_perf_unit.sv
module mc_perf_unit #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter logic [31:0] VERSION = 32'h0001_0A00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [7:0]    evt,
  output logic          irq
);
  localparam int NCNT = 8;
  localparam logic [AW-1:0] A_CTRL = AW'(12'h010);
  localparam logic [AW-1:0] A_EN   = AW'(12'h6C0);
  localparam logic [AW-1:0] A_MSK  = AW'(12'h6C8);
  localparam logic [AW-1:0] A_STS  = AW'(12'h6CC);
  localparam logic [AW-1:0] A_CLR  = AW'(12'h6D0);
  localparam logic [AW-1:0] A_VER  = AW'(12'h710);
  localparam logic [AW-1:0] CNT_OFF [NCNT] = '{
    AW'(12'h380), AW'(12'h384), AW'(12'h388), AW'(12'h38C),
    AW'(12'h3C0), AW'(12'h3C4), AW'(12'h3CC), AW'(12'h3D0)};

  logic                     glb_en;
  logic [NCNT-1:0]          ev_en, msk, sts, ovf, inc, wr_cnt;
  logic [NCNT-1:0][CW-1:0]  cnt;

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_en   = bus_we && bus_addr == A_EN;
  wire wr_msk  = bus_we && bus_addr == A_MSK;
  wire wr_clr  = bus_we && bus_addr == A_CLR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      glb_en <= 1'b0;
      ev_en  <= '0;
      msk    <= '1;
    end else begin
      if (wr_ctrl) glb_en <= bus_wdata[1];
      if (wr_en)   ev_en  <= bus_wdata[NCNT-1:0];
      if (wr_msk)  msk    <= bus_wdata[NCNT-1:0];
    end

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    assign wr_cnt[n] = bus_we && bus_addr == CNT_OFF[n];
    assign inc[n]    = glb_en && ev_en[n] && evt[n];
    assign ovf[n]    = inc[n] && !wr_cnt[n] && (&cnt[n]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         cnt[n] <= '0;
      else if (wr_cnt[n]) cnt[n] <= bus_wdata[CW-1:0];
      else if (inc[n])    cnt[n] <= cnt[n] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~(wr_clr ? bus_wdata[NCNT-1:0] : '0)) | ovf;

  assign irq = |(sts & ~msk);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1] = glb_en;
      A_EN:    bus_rdata[NCNT-1:0] = ev_en;
      A_MSK:   bus_rdata[NCNT-1:0] = msk;
      A_STS:   bus_rdata[NCNT-1:0] = sts;
      A_VER:   bus_rdata = DW'(VERSION);
      default:
        for (int n = 0; n < NCNT; n++)
          if (bus_addr == CNT_OFF[n]) bus_rdata[CW-1:0] = cnt[n];
    endcase
  end
endmodule

module mc_perf_unit_chk #(
  parameter int AW = 12,
  parameter int CW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic                glb_en,
  input logic [7:0]          ev_en,
  input logic [7:0]          msk,
  input logic [7:0]          sts,
  input logic [7:0][CW-1:0]  cnt,
  input logic                irq
);
  // R3
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !bus_we) |=> $stable(cnt));

  // R8
  sts_no_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(12'h6D0)) |=> ((sts & $past(sts)) == $past(sts)));

  // R7
  sts_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !bus_we) |=> $stable(sts));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == 8'hFF) |-> !irq);

  for (genvar n = 0; n < 8; n++) begin : g_c
    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_en[n] && !bus_we) |=> $stable(cnt[n]));
    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> (cnt[n] == $past(cnt[n]) || cnt[n] == $past(cnt[n]) + 1'b1));
  end
endmodule

bind mc_perf_unit mc_perf_unit_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .glb_en(glb_en), .ev_en(ev_en), .msk(msk), .sts(sts), .cnt(cnt), .irq(irq));

// File: tb/mc_perf_unit_tb.sv
module mc_perf_unit_tb;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  evt = '0;
  logic        irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mc_perf_unit u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt), .irq(irq));

  // {write, addr, data}: reads compare bus_rdata with data
  localparam int NV = 44;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0,12'h380,32'h0}, {1'b0,12'h384,32'h0}, {1'b0,12'h388,32'h0}, {1'b0,12'h38C,32'h0},
    {1'b0,12'h3C0,32'h0}, {1'b0,12'h3C4,32'h0}, {1'b0,12'h3CC,32'h0}, {1'b0,12'h3D0,32'h0},
    {1'b0,12'h010,32'h0}, {1'b0,12'h6C0,32'h0}, {1'b0,12'h6C8,32'hFF}, {1'b0,12'h6CC,32'h0},
    {1'b0,12'h710,32'h0001_0A00},
    {1'b1,12'h380,32'h1111_0000}, {1'b1,12'h384,32'h2222_0001}, {1'b1,12'h388,32'h3333_0002},
    {1'b1,12'h38C,32'h4444_0003}, {1'b1,12'h3C0,32'h5555_0004}, {1'b1,12'h3C4,32'h6666_0005},
    {1'b1,12'h3CC,32'h7777_0006}, {1'b1,12'h3D0,32'h8888_0007},
    {1'b0,12'h380,32'h1111_0000}, {1'b0,12'h384,32'h2222_0001}, {1'b0,12'h388,32'h3333_0002},
    {1'b0,12'h38C,32'h4444_0003}, {1'b0,12'h3C0,32'h5555_0004}, {1'b0,12'h3C4,32'h6666_0005},
    {1'b0,12'h3CC,32'h7777_0006}, {1'b0,12'h3D0,32'h8888_0007},
    {1'b0,12'h3C8,32'h0}, {1'b0,12'h004,32'h0},
    {1'b1,12'h710,32'hDEAD_BEEF}, {1'b0,12'h710,32'h0001_0A00},
    {1'b1,12'h6CC,32'hFF}, {1'b0,12'h6CC,32'h0},
    {1'b1,12'h380,32'h0}, {1'b1,12'h384,32'h0}, {1'b1,12'h388,32'h0}, {1'b1,12'h38C,32'h0},
    {1'b1,12'h3C0,32'h0}, {1'b1,12'h3C4,32'h0}, {1'b1,12'h3CC,32'h0}, {1'b1,12'h3D0,32'h0},
    {1'b0,12'h3D0,32'h0}};

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_we = 0; #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    #1; checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", req, irq, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] e, input int n);
    @(negedge clk); evt = e;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_irq(1'b0, "R1");
    // R1 reset values, R5 offsets, R10 version, R11 ignored/unmapped
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
      else rd(VEC[i][43:32], VEC[i][31:0], "R1/R5/R10/R11 table");
    end
    // R3 only bit 1 stored
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h2, "R3 ctrl bits");
    // R2 counting
    wr(12'h6C0, 32'hFF);
    pulse(8'b1010_0101, 5);
    rd(12'h380, 5, "R2 cnt0");
    rd(12'h384, 0, "R2 cnt1");
    rd(12'h388, 5, "R2 cnt2");
    rd(12'h3C4, 5, "R2 cnt5");
    rd(12'h3D0, 5, "R2 cnt7");
    // R3 global off
    wr(12'h010, 32'h0);
    pulse(8'hFF, 4);
    rd(12'h380, 5, "R3 cnt0 held");
    rd(12'h384, 0, "R3 cnt1 held");
    // R4 per-counter off
    wr(12'h010, 32'h2);
    wr(12'h6C0, 32'h01);
    pulse(8'hFF, 3);
    rd(12'h380, 8, "R4 cnt0 runs");
    rd(12'h388, 5, "R4 cnt2 held");
    // R6 write beats increment
    @(negedge clk); bus_addr = 12'h380; bus_wdata = 32'd100; bus_we = 1; evt = 8'h01;
    @(negedge clk); bus_we = 0; evt = 8'h00;
    rd(12'h380, 100, "R6 write priority");
    // R7 overflow
    wr(12'h38C, 32'hFFFF_FFFE);
    wr(12'h6C0, 32'h08);
    pulse(8'h08, 1);
    rd(12'h38C, 32'hFFFF_FFFF, "R7 at max");
    rd(12'h6CC, 0, "R7 no flag yet");
    pulse(8'h08, 1);
    rd(12'h38C, 0, "R7 wrapped");
    rd(12'h6CC, 32'h08, "R7 flag set");
    chk_irq(1'b0, "R9 masked");
    wr(12'h6C8, 32'hF7);
    chk_irq(1'b1, "R9 unmasked");
    wr(12'h6C8, 32'hFB);
    chk_irq(1'b0, "R9 other bit unmasked");
    wr(12'h6C8, 32'h00);
    // R11 status write ignored
    wr(12'h6CC, 32'h0);
    rd(12'h6CC, 32'h08, "R11 sts write ignored");
    // R8 clear semantics
    wr(12'h6D0, 32'hF7);
    rd(12'h6CC, 32'h08, "R8 zero bit kept");
    wr(12'h6D0, 32'h08);
    rd(12'h6CC, 0, "R8 one clears");
    chk_irq(1'b0, "R9 after clear");
    // R8 clear collides with overflow
    wr(12'h38C, 32'hFFFF_FFFF);
    @(negedge clk); bus_addr = 12'h6D0; bus_wdata = 32'h08; bus_we = 1; evt = 8'h08;
    @(negedge clk); bus_we = 0; evt = 8'h00;
    rd(12'h6CC, 32'h08, "R8 overflow wins clear");
    rd(12'h38C, 0, "R7 wrap on collision");
    chk_irq(1'b1, "R9 pending");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule